// File: doc/BRIEF.md
# Device Metadata Response Generator

This block answers a metadata request from a host with a self-describing list of records. It sends the list one byte at a time over a ready/valid byte stream, which normally feeds a UART transmitter. Each record starts with a key byte. The upper three bits of the key give the value format and the lower five bits name the field. The value follows in the format that the key selects, and a lone zero key closes the list.

The text fields are set at build time by parameters. These are the device name, the main firmware version and an optional auxiliary version. The numeric fields are taken from input ports at the moment a request is accepted. These are the usable probe count, the sample memory size, the highest sample rate and the protocol version. Decoding the request command and the serial line itself belong to neighbouring blocks.

Top module: `meta_resp_gen`

## Requirements
- R1: Every key byte carries the value format in bits 7:5 and the field token in bits 4:0. Format 0 is a zero-terminated string, format 1 is an unsigned 32-bit value of four bytes, and format 2 is an unsigned 8-bit value of one byte.
- R2: The records leave in this fixed order:
  - device name (key 0x01)
  - main firmware version (key 0x02)
  - auxiliary version (key 0x03, when enabled)
  - probe count
  - sample memory bytes (key 0x21)
  - highest sample rate in Hz (key 0x23)
  - protocol version (key 0x41)
  - closing key 0x00
- R3: A string value is the parameter's characters, leftmost character first, followed by exactly one 0x00 byte.
- R4: A 32-bit value is sent most significant byte first.
- R5: With PROBE_AS_BYTE = 0 the probe count record is key 0x20 plus four bytes. With PROBE_AS_BYTE = 1 it is key 0x40 plus the low byte of the count.
- R6: With ANC_EN = 0 the auxiliary version record is left out entirely, and all other records keep their order.
- R7: The numeric inputs are captured in the cycle a request is accepted. Changing them during the response does not alter any byte sent.
- R8: While m_valid is high and m_ready is low, m_valid stays high and m_data holds its value.
- R9: done is high for exactly one cycle, in the cycle after the closing key is accepted. m_valid is low in that cycle.
- R10: A request that arrives while a response is in progress is ignored. The response is neither restarted nor repeated, and only one done pulse appears.
- R11: After reset, m_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Metadata request pulse |
| probe_count | input | 32 | Number of usable probes |
| mem_bytes | input | 32 | Sample memory size in bytes |
| max_rate_hz | input | 32 | Highest sample rate in Hz |
| proto_ver | input | 8 | Protocol version |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | 8 | Output byte |
| done | output | 1 | One-cycle pulse after the closing key is accepted |

## Verification
The assertions check the stream handshake on every cycle: a stalled byte keeps valid high and its value steady. They also check the done pulse: it is single, it follows an accepted zero byte, and valid is low while it is high.

Only the bench's scenarios can show the rest:
- that the byte sequence matches the record layout, in both probe formats and with the auxiliary record on and off;
- that the numeric values are frozen at request time;
- that a request made during a response is ignored.

The bench drives these under several ready patterns.

// File: rtl/meta_pkg.sv
package meta_pkg;

  // Order of records in the response; the sequencer walks this list.
  typedef enum logic [2:0] {
    REC_NAME   = 3'd0,
    REC_FW     = 3'd1,
    REC_ANC    = 3'd2,
    REC_PROBES = 3'd3,
    REC_MEM    = 3'd4,
    REC_RATE   = 3'd5,
    REC_PROTO  = 3'd6,
    REC_END    = 3'd7
  } rec_e;

  // Value formats held in key bits 7:5.
  localparam logic [2:0] FMT_STR = 3'd0;
  localparam logic [2:0] FMT_U32 = 3'd1;
  localparam logic [2:0] FMT_U8  = 3'd2;

  // Field tokens held in key bits 4:0.
  localparam logic [4:0] TOK_NAME   = 5'h01;
  localparam logic [4:0] TOK_FW     = 5'h02;
  localparam logic [4:0] TOK_ANC    = 5'h03;
  localparam logic [4:0] TOK_PROBES = 5'h00;
  localparam logic [4:0] TOK_MEM    = 5'h01;
  localparam logic [4:0] TOK_RATE   = 5'h03;
  localparam logic [4:0] TOK_PROTO  = 5'h01;

  // Numeric values captured when a request is accepted.
  typedef struct packed {
    logic [31:0] probes;
    logic [31:0] mem;
    logic [31:0] rate;
    logic [7:0]  proto;
  } info_t;

  function automatic logic [7:0] make_key(input logic [2:0] fmt, input logic [4:0] tok);
    return {fmt, tok};
  endfunction

endpackage

// File: rtl/meta_req_ctl.sv
module meta_req_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic end_acc,
  output logic start,
  output logic busy,
  output logic done
);

  // A request only starts a response while the block is idle.
  assign start = req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= end_acc;
      if (start) begin
        busy <= 1'b1;
      end else if (end_acc) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/meta_rec_seq.sv
module meta_rec_seq
  import meta_pkg::*;
#(
  parameter int NAME_LEN = 8,
  parameter logic [8*NAME_LEN-1:0] NAME_STR = "LogicCap",
  parameter int FW_LEN = 5,
  parameter logic [8*FW_LEN-1:0] FW_STR = "v3.07",
  parameter bit ANC_EN = 1'b1,
  parameter int ANC_LEN = 4,
  parameter logic [8*ANC_LEN-1:0] ANC_STR = "b1.2",
  parameter bit PROBE_AS_BYTE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       advance,
  input  info_t      info_in,
  output logic [7:0] byte_o,
  output logic       end_o,
  output logic       exhausted_o
);

  localparam int MAX_A = (NAME_LEN > FW_LEN) ? NAME_LEN : FW_LEN;
  localparam int MAX_S = ((MAX_A > ANC_LEN) ? MAX_A : ANC_LEN) + 1;
  localparam int SPAN  = (MAX_S > 4) ? MAX_S : 4;
  localparam int POS_W = $clog2(SPAN + 1);

  rec_e             rec;
  rec_e             nxt;
  logic [POS_W-1:0] pos;
  info_t            snap;
  logic             exhausted;
  logic             last;
  logic [7:0]       probe_key;
  logic [2:0]       probe_vlen;
  int               p;

  // The parameter picks the probe count record format.
  if (PROBE_AS_BYTE) begin : g_probe_u8
    assign probe_key  = make_key(FMT_U8, TOK_PROBES);
    assign probe_vlen = 3'd1;
  end else begin : g_probe_u32
    assign probe_key  = make_key(FMT_U32, TOK_PROBES);
    assign probe_vlen = 3'd4;
  end

  // Record after the current one; the auxiliary record may be skipped.
  always_comb begin
    nxt = rec_e'(3'(rec) + 3'd1);
    if (rec == REC_FW && !ANC_EN) begin
      nxt = REC_PROBES;
    end
  end

  assign p = int'(pos);

  // Byte at the current position of the current record.
  always_comb begin
    byte_o = 8'h00;
    last   = 1'b0;
    unique case (rec)
      REC_NAME: begin
        if (p == 0) begin
          byte_o = make_key(FMT_STR, TOK_NAME);
        end else if (p <= NAME_LEN) begin
          byte_o = 8'(NAME_STR >> (8 * (NAME_LEN - p)));
        end
        last = (p == NAME_LEN + 1);
      end
      REC_FW: begin
        if (p == 0) begin
          byte_o = make_key(FMT_STR, TOK_FW);
        end else if (p <= FW_LEN) begin
          byte_o = 8'(FW_STR >> (8 * (FW_LEN - p)));
        end
        last = (p == FW_LEN + 1);
      end
      REC_ANC: begin
        if (p == 0) begin
          byte_o = make_key(FMT_STR, TOK_ANC);
        end else if (p <= ANC_LEN) begin
          byte_o = 8'(ANC_STR >> (8 * (ANC_LEN - p)));
        end
        last = (p == ANC_LEN + 1);
      end
      REC_PROBES: begin
        if (p == 0) begin
          byte_o = probe_key;
        end else begin
          byte_o = 8'(snap.probes >> (8 * (int'(probe_vlen) - p)));
        end
        last = (p == int'(probe_vlen));
      end
      REC_MEM: begin
        if (p == 0) begin
          byte_o = make_key(FMT_U32, TOK_MEM);
        end else begin
          byte_o = 8'(snap.mem >> (8 * (4 - p)));
        end
        last = (p == 4);
      end
      REC_RATE: begin
        if (p == 0) begin
          byte_o = make_key(FMT_U32, TOK_RATE);
        end else begin
          byte_o = 8'(snap.rate >> (8 * (4 - p)));
        end
        last = (p == 4);
      end
      REC_PROTO: begin
        if (p == 0) begin
          byte_o = make_key(FMT_U8, TOK_PROTO);
        end else begin
          byte_o = snap.proto;
        end
        last = (p == 1);
      end
      default: begin
        byte_o = 8'h00;
        last   = 1'b1;
      end
    endcase
  end

  assign end_o       = (rec == REC_END);
  assign exhausted_o = exhausted;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec       <= REC_END;
      pos       <= '0;
      snap      <= '0;
      exhausted <= 1'b1;
    end else if (start) begin
      rec       <= REC_NAME;
      pos       <= '0;
      snap      <= info_in;
      exhausted <= 1'b0;
    end else if (advance) begin
      if (rec == REC_END) begin
        exhausted <= 1'b1;
      end else if (last) begin
        rec <= nxt;
        pos <= '0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/meta_byte_out.sv
module meta_byte_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       gen_ok,
  input  logic [7:0] byte_i,
  input  logic       end_i,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       advance,
  output logic       end_acc
);

  logic last_q;

  // Load a new byte when the slot is empty or being emptied this cycle.
  assign advance = gen_ok && (!m_valid || m_ready);
  assign end_acc = m_valid && m_ready && last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= 8'h00;
      last_q  <= 1'b0;
    end else if (advance) begin
      m_valid <= 1'b1;
      m_data  <= byte_i;
      last_q  <= end_i;
    end else if (m_ready) begin
      m_valid <= 1'b0;
      last_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/meta_resp_gen.sv
module meta_resp_gen
  import meta_pkg::*;
#(
  parameter int NAME_LEN = 8,
  parameter logic [8*NAME_LEN-1:0] NAME_STR = "LogicCap",
  parameter int FW_LEN = 5,
  parameter logic [8*FW_LEN-1:0] FW_STR = "v3.07",
  parameter bit ANC_EN = 1'b1,
  parameter int ANC_LEN = 4,
  parameter logic [8*ANC_LEN-1:0] ANC_STR = "b1.2",
  parameter bit PROBE_AS_BYTE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [31:0] probe_count,
  input  logic [31:0] mem_bytes,
  input  logic [31:0] max_rate_hz,
  input  logic [7:0]  proto_ver,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  output logic        done
);

  logic       start;
  logic       busy;
  logic       advance;
  logic       end_acc;
  logic [7:0] seq_byte;
  logic       seq_end;
  logic       seq_exhausted;
  info_t      info_in;

  assign info_in = '{probes: probe_count, mem: mem_bytes, rate: max_rate_hz, proto: proto_ver};

  meta_req_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .end_acc (end_acc),
    .start   (start),
    .busy    (busy),
    .done    (done)
  );

  meta_rec_seq #(
    .NAME_LEN      (NAME_LEN),
    .NAME_STR      (NAME_STR),
    .FW_LEN        (FW_LEN),
    .FW_STR        (FW_STR),
    .ANC_EN        (ANC_EN),
    .ANC_LEN       (ANC_LEN),
    .ANC_STR       (ANC_STR),
    .PROBE_AS_BYTE (PROBE_AS_BYTE)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .advance     (advance),
    .info_in     (info_in),
    .byte_o      (seq_byte),
    .end_o       (seq_end),
    .exhausted_o (seq_exhausted)
  );

  meta_byte_out u_out (
    .clk     (clk),
    .rst     (rst),
    .gen_ok  (busy && !seq_exhausted),
    .byte_i  (seq_byte),
    .end_i   (seq_end),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .advance (advance),
    .end_acc (end_acc)
  );

endmodule

// File: rtl/meta_resp_chk.sv
module meta_resp_chk (
  input logic       clk,
  input logic       rst,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       done
);

  // R8: a stalled byte keeps valid asserted
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid);

  // R8: a stalled byte keeps its value
  a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> $stable(m_data));

  // R9: done follows an accepted zero byte
  a_r9_done_after_zero: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(m_valid && m_ready && (m_data == 8'h00)));

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: no byte is offered while done is high
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !m_valid);

endmodule

bind meta_resp_gen meta_resp_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .done    (done)
);

// File: tb/sim_meta_resp_gen.sv
module sim_meta_resp_gen;

  localparam int NL0 = 8;
  localparam logic [8*NL0-1:0] NS0 = "LogicCap";
  localparam int FL0 = 5;
  localparam logic [8*FL0-1:0] FS0 = "v3.07";
  localparam int AL0 = 4;
  localparam logic [8*AL0-1:0] AS0 = "b1.2";
  localparam int NL1 = 3;
  localparam logic [8*NL1-1:0] NS1 = "Tap";
  localparam int FL1 = 6;
  localparam logic [8*FL1-1:0] FS1 = "fw-2.1";
  localparam int AL1 = 1;
  localparam logic [8*AL1-1:0] AS1 = "x";

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req0 = 1'b0, req1 = 1'b0;
  logic        rdy0 = 1'b0, rdy1 = 1'b0;
  logic [31:0] pc = '0, mem = '0, rate = '0;
  logic [7:0]  pv = '0;
  logic        v0, v1, dn0, dn1;
  logic [7:0]  d0, d1;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  int probe_idx;

  always #4 clk = ~clk;

  meta_resp_gen #(
    .NAME_LEN(NL0), .NAME_STR(NS0), .FW_LEN(FL0), .FW_STR(FS0),
    .ANC_EN(1'b1), .ANC_LEN(AL0), .ANC_STR(AS0), .PROBE_AS_BYTE(1'b0)
  ) u0 (
    .clk(clk), .rst(rst), .req(req0), .probe_count(pc), .mem_bytes(mem),
    .max_rate_hz(rate), .proto_ver(pv), .m_valid(v0), .m_ready(rdy0),
    .m_data(d0), .done(dn0)
  );

  meta_resp_gen #(
    .NAME_LEN(NL1), .NAME_STR(NS1), .FW_LEN(FL1), .FW_STR(FS1),
    .ANC_EN(1'b0), .ANC_LEN(AL1), .ANC_STR(AS1), .PROBE_AS_BYTE(1'b1)
  ) u1 (
    .clk(clk), .rst(rst), .req(req1), .probe_count(pc), .mem_bytes(mem),
    .max_rate_hz(rate), .proto_ver(pv), .m_valid(v1), .m_ready(rdy1),
    .m_data(d1), .done(dn1)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, expv);
    end
  endtask

  function automatic void push_str(input logic [127:0] s, input int len);
    for (int k = 0; k < len; k++) exp_q.push_back(8'(s >> (8 * (len - 1 - k))));
    exp_q.push_back(8'h00);
  endfunction

  function automatic void push_u32(input logic [31:0] x);
    for (int k = 3; k >= 0; k--) exp_q.push_back(8'(x >> (8 * k)));
  endfunction

  // Expected response built from the record layout in the requirements.
  function automatic void build_exp(input bit alt, input logic [31:0] p,
                                    input logic [31:0] m, input logic [31:0] r,
                                    input logic [7:0] v);
    exp_q.delete();
    exp_q.push_back(8'h01);
    if (alt) push_str(128'(NS1), NL1); else push_str(128'(NS0), NL0);
    exp_q.push_back(8'h02);
    if (alt) push_str(128'(FS1), FL1); else push_str(128'(FS0), FL0);
    if (!alt) begin
      exp_q.push_back(8'h03);
      push_str(128'(AS0), AL0);
    end
    probe_idx = exp_q.size();
    if (alt) begin
      exp_q.push_back(8'h40);
      exp_q.push_back(p[7:0]);
    end else begin
      exp_q.push_back(8'h20);
      push_u32(p);
    end
    exp_q.push_back(8'h21); push_u32(m);
    exp_q.push_back(8'h23); push_u32(r);
    exp_q.push_back(8'h41); exp_q.push_back(v);
    exp_q.push_back(8'h00);
  endfunction

  task automatic run(input bit alt, input int rmode, input bit perturb, input bit rereq,
                     input logic [31:0] p, input logic [31:0] m, input logic [31:0] r,
                     input logic [7:0] v, input string tag);
    logic [7:0] got[$];
    bit exp_done_next = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;
    int dones = 0;
    int cyc = 0;
    bit rdy;
    logic vs, dn;
    logic [7:0] ds;
    pc = p; mem = m; rate = r; pv = v;
    build_exp(alt, p, m, r, v);
    @(negedge clk);
    if (alt) req1 = 1'b1; else req0 = 1'b1;
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
    while (dones == 0 && cyc < 5000) begin
      vs = alt ? v1 : v0;
      ds = alt ? d1 : d0;
      dn = alt ? dn1 : dn0;
      if (dn || exp_done_next)
        chk(dn == exp_done_next, "R9", {tag, " done one cycle after end key"}, 32'(dn), 32'(exp_done_next));
      if (dn) dones++;
      if (prev_stall)
        chk(vs && ds == prev_data, "R8", {tag, " stalled byte held"}, {23'd0, vs, ds}, {23'd1, prev_data});
      case (rmode)
        0: rdy = 1'b1;
        1: rdy = ($urandom % 2) == 0;
        default: rdy = ($urandom % 5) == 0;
      endcase
      if (alt) rdy1 = rdy; else rdy0 = rdy;
      exp_done_next = 1'b0;
      if (vs && rdy && !dn) begin
        got.push_back(ds);
        if (got.size() == exp_q.size()) exp_done_next = 1'b1;
      end
      prev_stall = vs && !rdy;
      prev_data  = ds;
      if (perturb && cyc == 6) begin
        pc = ~p; mem = m ^ 32'hA5A5_0F0F; rate = r + 32'd1; pv = ~v;
      end
      if (rereq && cyc == 8) begin
        if (alt) req1 = 1'b1; else req0 = 1'b1;
      end
      if (rereq && cyc == 9) begin
        req0 = 1'b0; req1 = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    chk(dones == 1, "R9", {tag, " done seen"}, 32'(dones), 32'd1);
    chk(got.size() == exp_q.size(), alt ? "R6" : "R2", {tag, " response length"},
        32'(got.size()), 32'(exp_q.size()));
    if (got.size() == exp_q.size()) begin
      for (int i = 0; i < got.size(); i++)
        chk(got[i] == exp_q[i], perturb ? "R7" : "R2 R3 R4", $sformatf("%s byte %0d", tag, i),
            32'(got[i]), 32'(exp_q[i]));
      chk(got[0][7:5] == 3'd0 && got[probe_idx][7:5] == (alt ? 3'd2 : 3'd1), "R1",
          {tag, " key format fields"}, {got[0], got[probe_idx]}, {exp_q[0], exp_q[probe_idx]});
      chk(got[probe_idx] == (alt ? 8'h40 : 8'h20), "R5", {tag, " probe key"},
          32'(got[probe_idx]), alt ? 32'h40 : 32'h20);
    end
    // After done: nothing more, no restart from an ignored request.
    rdy0 = 1'b1; rdy1 = 1'b1;
    dones = 0;
    for (int i = 0; i < 12; i++) begin
      if ((alt ? v1 : v0) || (alt ? dn1 : dn0)) dones++;
      @(negedge clk);
    end
    chk(dones == 0, "R10", {tag, " idle after response"}, 32'(dones), 32'd0);
    rdy0 = 1'b0; rdy1 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!v0 && !dn0 && !v1 && !dn1, "R11", "outputs low after reset",
        {v0, dn0, v1, dn1}, 32'd0);
    run(1'b0, 0, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, 8'h00, "zeros ready");
    run(1'b0, 2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, "ones sparse");
    run(1'b0, 1, 1'b0, 1'b0, 32'd32, 32'h0060_0000, 32'd200_000_000, 8'h02, "typical");
    run(1'b0, 1, 1'b1, 1'b0, $urandom, $urandom, $urandom, 8'($urandom), "R7 change");
    run(1'b0, 0, 1'b0, 1'b1, $urandom, $urandom, $urandom, 8'($urandom), "R10 rereq");
    run(1'b1, 1, 1'b0, 1'b0, 32'h0000_0110, $urandom, $urandom, 8'h05, "alt R5 R6");
    run(1'b1, 2, 1'b1, 1'b1, $urandom, $urandom, $urandom, 8'($urandom), "alt R7 R10");
    for (int k = 0; k < 6; k++)
      run(1'($urandom % 2), int'($urandom % 3), 1'($urandom % 2), 1'($urandom % 2),
          $urandom, $urandom, $urandom, 8'($urandom), $sformatf("rand%0d", k));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule